// File: doc/BRIEF.md
# Instruction Cache Set Parity Scrubber

The block walks one set of a four-way instruction cache and checks every parity field it holds. A single start pulse, together with a set index and a data-check enable, launches a scan. For each way, in order 0 to 3, the block reads the raw tag through a synchronous read port. The port returns a 32-bit high word and a 64-bit low word one cycle after the address is presented. When the data check is enabled, the block also reads the four data entries of that way before it moves to the next way. In a data entry the low word holds two instructions (A in the upper half, B in the lower half), and the high word is a side word that carries predecode and parity bits.

Each returned word is recomputed against its stored parity. The results are collected into a tag-parity flag, a data-parity flag and a per-way error vector. The block also captures the replacement-order field from way 0. A one-cycle done pulse marks the end of the scan. The results then stay put until the next scan is launched, so diagnostic software or a scrub sequencer can read them at leisure.

Top module: `icache_set_scrub`

## Requirements
- R1: Reads go out one per cycle, in way order 0 to 3. Each way starts with a tag read (rd_kind=0) at address (way<<13)|set_idx. When check_data is set, the tag read is followed by data reads (rd_kind=1) for offsets 0 to 3 at address (way<<13)|set_idx|(offset<<3). The first read is issued in the cycle after start is accepted.
- R2: The valid bit is tag-high bit 29 and its parity copy is bit 27. A difference between them sets tag_err and the way's way_err bit, whatever the value of the valid bit.
- R3: For a line whose valid bit is 1, tag-low bit 10 must equal the XOR of tag-low bits 23..0 excluding bits 10 and 11, and tag-low bit 11 must equal the XOR of tag-low bits 63..24. A mismatch sets tag_err and way_err. For a line whose valid bit is 0, both of these checks are ignored.
- R4: With check_data low, no data read is issued, and corrupted data entries do not affect data_err or way_err.
- R5: Side-word bit 16 must equal the XOR of side-word bits 15..8 (the predecode byte). A mismatch sets data_err and way_err.
- R6: Side-word bits 7..4 hold the even byte parities of instruction A (low-word bits 63..32), and bits 3..0 those of instruction B (low-word bits 31..0). Bit 4+k, or bit k for B, is the XOR of byte k of the instruction, so the most significant byte maps to the most significant parity bit. A mismatch sets data_err and way_err.
- R7: At done, way_err[w] is 1 exactly when some check on way w failed, so way_err is nonzero exactly when tag_err or data_err is 1.
- R8: lru_order equals bits 21..14 of way 0's tag high word. It holds four 2-bit way numbers, least recently used in bits 1..0.
- R9: done is high for exactly one cycle, in the cycle after the last read's data is returned. The flags and lru_order are cleared when a start is accepted and otherwise hold their values while the block is idle.
- R10: A start pulse while busy is high is ignored: the read sequence and the results of the scan in progress are unchanged.
- R11: After reset, busy, done, rd_en, tag_err, data_err, way_err and lru_order are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a scan (accepted only when idle) |
| set_idx | input | IDX_W (13) | Set index ORed into every read address |
| check_data | input | 1 | Also read and check the data entries |
| rd_en | output | 1 | Read request to the cache arrays |
| rd_kind | output | 1 | 0 = tag read, 1 = data read |
| rd_addr | output | ADDR_W (16) | Read address |
| rd_hi | input | 32 | Returned tag high word or side word, one cycle after rd_en |
| rd_lo | input | 64 | Returned tag low word or instruction pair |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| tag_err | output | 1 | Some tag parity check failed |
| data_err | output | 1 | Some data parity check failed |
| way_err | output | WAYS (4) | Per-way error vector |
| lru_order | output | 8 | Replacement-order field of way 0 |

## Verification
The bench builds the block with its default parameters: four ways, four data entries per way, the way field at bit 13 and the offset at bit 3. This lets a small model in the bench decode each address back to a way and an offset, and check every address of a 4-read scan and of a 20-read scan. The tests inject single-bit faults into each parity field. They also use paired flips that cancel out only when the byte-to-parity-bit order is right, and faults placed on invalid lines and in data while the data check is off, to show where checks must stay silent. A start pulse in the middle of a scan checks that a scan in progress cannot be disturbed.

// File: rtl/icache_set_scrub.sv
module icache_set_scrub #(
  parameter int WAYS      = 4,
  parameter int OFFS      = 4,
  parameter int IDX_W     = 13,
  parameter int ADDR_W    = 16,
  parameter int WAY_SHIFT = 13,
  parameter int OFF_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              check_data,
  output logic              rd_en,
  output logic              rd_kind,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_hi,
  input  logic [63:0]       rd_lo,
  output logic              busy,
  output logic              done,
  output logic              tag_err,
  output logic              data_err,
  output logic [WAYS-1:0]   way_err,
  output logic [7:0]        lru_order
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int OFF_W = (OFFS > 1) ? $clog2(OFFS) : 1;
  localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(WAYS - 1);
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(OFFS - 1);

  logic             issue_q, in_data_q, chk_q;
  logic [WAY_W-1:0] way_q;
  logic [OFF_W-1:0] off_q;
  logic [IDX_W-1:0] idx_q;
  logic             rv_q, rkind_q, rlast_q, done_q;
  logic [WAY_W-1:0] rway_q;
  logic             tag_err_q, data_err_q;
  logic [WAYS-1:0]  way_err_q;
  logic [7:0]       lru_q;

  logic accept, last_issue;
  assign busy       = issue_q | rv_q;
  assign accept     = start & ~busy;
  assign last_issue = (way_q == WAY_MAX) && (!chk_q || (in_data_q && off_q == OFF_MAX));

  assign rd_en   = issue_q;
  assign rd_kind = in_data_q;
  assign rd_addr = (ADDR_W'(way_q) << WAY_SHIFT) | ADDR_W'(idx_q)
                 | (in_data_q ? (ADDR_W'(off_q) << OFF_SHIFT) : '0);

  logic       tag_bad, pre_bad, ins_bad, data_bad, resp_bad;
  logic [3:0] par_a, par_b;
  logic       unused_hi;

  assign tag_bad = (rd_hi[29] ^ rd_hi[27])
                 | (rd_hi[29] & ((rd_lo[10] ^ (^(rd_lo[23:0] & 24'hFFF3FF)))
                               | (rd_lo[11] ^ (^rd_lo[63:24]))));

  for (genvar b = 0; b < 4; b++) begin : g_byte
    assign par_a[b] = ^rd_lo[32 + 8*b +: 8];
    assign par_b[b] = ^rd_lo[8*b +: 8];
  end

  assign pre_bad  = rd_hi[16] ^ (^rd_hi[15:8]);
  assign ins_bad  = (rd_hi[7:4] != par_a) | (rd_hi[3:0] != par_b);
  assign data_bad = pre_bad | ins_bad;
  assign resp_bad = rkind_q ? data_bad : tag_bad;
  assign unused_hi = ^{rd_hi[31:30], rd_hi[28], rd_hi[26:22]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_q   <= 1'b0;
      in_data_q <= 1'b0;
      chk_q     <= 1'b0;
      way_q     <= '0;
      off_q     <= '0;
      idx_q     <= '0;
    end else if (accept) begin
      issue_q   <= 1'b1;
      in_data_q <= 1'b0;
      chk_q     <= check_data;
      way_q     <= '0;
      off_q     <= '0;
      idx_q     <= set_idx;
    end else if (issue_q) begin
      if (last_issue) begin
        issue_q   <= 1'b0;
        in_data_q <= 1'b0;
      end else if (!in_data_q) begin
        if (chk_q) begin
          in_data_q <= 1'b1;
          off_q     <= '0;
        end else begin
          way_q <= way_q + 1'b1;
        end
      end else if (off_q == OFF_MAX) begin
        in_data_q <= 1'b0;
        way_q     <= way_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rkind_q <= 1'b0;
      rlast_q <= 1'b0;
      rway_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      rv_q    <= issue_q;
      rkind_q <= in_data_q;
      rlast_q <= issue_q & last_issue;
      rway_q  <= way_q;
      done_q  <= rv_q & rlast_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accept) begin
      tag_err_q  <= 1'b0;
      data_err_q <= 1'b0;
      way_err_q  <= '0;
      lru_q      <= '0;
    end else if (rv_q) begin
      if (!rkind_q && tag_bad)  tag_err_q  <= 1'b1;
      if (rkind_q && data_bad)  data_err_q <= 1'b1;
      if (resp_bad)             way_err_q[rway_q] <= 1'b1;
      if (!rkind_q && rway_q == '0) lru_q <= rd_hi[21:14];
    end
  end

  assign done      = done_q;
  assign tag_err   = tag_err_q;
  assign data_err  = data_err_q;
  assign way_err   = way_err_q;
  assign lru_order = lru_q;
endmodule

module icache_set_scrub_chk #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            rd_en,
  input logic            rd_kind,
  input logic            tag_err,
  input logic            data_err,
  input logic [WAYS-1:0] way_err
);
  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && rd_en && !rd_kind));

  assert_read_in_scan_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  assert_summary_agrees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((|way_err) == (tag_err || data_err)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({tag_err, data_err, way_err}));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind icache_set_scrub icache_set_scrub_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_en(rd_en), .rd_kind(rd_kind), .tag_err(tag_err), .data_err(data_err),
  .way_err(way_err)
);

// File: tb/sim_icache_set_scrub.sv
module sim_icache_set_scrub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] set_idx = '0;
  logic        check_data = 1'b0;
  logic        rd_en, rd_kind, busy, done, tag_err, data_err;
  logic [15:0] rd_addr;
  logic [31:0] rd_hi = '0;
  logic [63:0] rd_lo = '0;
  logic [3:0]  way_err;
  logic [7:0]  lru_order;

  always #4 clk = ~clk;

  icache_set_scrub u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .set_idx(set_idx),
    .check_data(check_data), .rd_en(rd_en), .rd_kind(rd_kind),
    .rd_addr(rd_addr), .rd_hi(rd_hi), .rd_lo(rd_lo), .busy(busy),
    .done(done), .tag_err(tag_err), .data_err(data_err),
    .way_err(way_err), .lru_order(lru_order)
  );

  logic [31:0] m_thi [4];
  logic [63:0] m_tlo [4];
  logic [31:0] m_side[4][4];
  logic [63:0] m_dlo [4][4];

  always @(posedge clk) begin
    if (rd_en) begin
      if (rd_kind) begin
        rd_hi <= m_side[rd_addr[14:13]][rd_addr[4:3]];
        rd_lo <= m_dlo[rd_addr[14:13]][rd_addr[4:3]];
      end else begin
        rd_hi <= m_thi[rd_addr[14:13]];
        rd_lo <= m_tlo[rd_addr[14:13]];
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  function automatic void check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  logic [16:0] addr_q[$];
  logic [13:0] res_q[$];
  string       req_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) begin
        if (addr_q.size() == 0) check(1'b0, "R1 unexpected read", {47'b0, rd_kind, rd_addr}, 64'h0);
        else begin
          logic [16:0] e;
          e = addr_q.pop_front();
          check({rd_kind, rd_addr} == e, "R1 read order/address", {47'b0, rd_kind, rd_addr}, {47'b0, e});
        end
      end
      if (done) begin
        if (res_q.size() == 0) check(1'b0, "R9 unexpected done", 64'h1, 64'h0);
        else begin
          logic [13:0] r;
          string s;
          r = res_q.pop_front();
          s = req_q.pop_front();
          check({tag_err, data_err, way_err, lru_order} == r, s,
                {50'b0, tag_err, data_err, way_err, lru_order}, {50'b0, r});
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mix(input int s);
    logic [31:0] v;
    v = 32'(s) * 32'h9E3779B1;
    return v ^ (v >> 15) ^ 32'h5BD1E995;
  endfunction

  function automatic logic [3:0] bpar(input logic [31:0] x);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ^x[8*b +: 8];
    return p;
  endfunction

  task automatic fill(input int seed, input logic [7:0] lru);
    for (int w = 0; w < 4; w++) begin
      logic [63:0] lo;
      logic [31:0] hi;
      lo = {mix(seed + w*31), mix(seed + w*31 + 1)};
      lo[11:10] = 2'b00;
      lo[10] = ^lo[23:0];
      lo[11] = ^lo[63:24];
      hi = mix(seed + w*31 + 2);
      hi[29] = 1'b1;
      hi[27] = 1'b1;
      if (w == 0) hi[21:14] = lru;
      m_thi[w] = hi;
      m_tlo[w] = lo;
      for (int o = 0; o < 4; o++) begin
        logic [31:0] a, b;
        logic [7:0]  pre;
        a = mix(seed + w*31 + o*5 + 3);
        b = mix(seed + w*31 + o*5 + 4);
        pre = mix(seed + w*31 + o*5 + 5)[7:0];
        m_side[w][o] = {15'h0, ^pre, pre, bpar(a), bpar(b)};
        m_dlo[w][o]  = {a, b};
      end
    end
  endtask

  task automatic run(input logic [12:0] idx, input bit chk, input bit et, input bit ed,
                     input logic [3:0] ew, input logic [7:0] el, input string req, input bit poke);
    for (int w = 0; w < 4; w++) begin
      addr_q.push_back({1'b0, 16'(w << 13) | 16'(idx)});
      if (chk) for (int o = 0; o < 4; o++)
        addr_q.push_back({1'b1, 16'(w << 13) | 16'(idx) | 16'(o << 3)});
    end
    res_q.push_back({et, ed, ew, el});
    req_q.push_back(req);
    @(negedge clk);
    start = 1'b1; set_idx = idx; check_data = chk;
    @(negedge clk);
    start = 1'b0;
    check({tag_err, data_err, way_err, lru_order} == 14'h0, "R9 flags cleared on start",
          {50'b0, tag_err, data_err, way_err, lru_order}, 64'h0);
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      start = 1'b1; set_idx = 13'h1040; check_data = ~chk;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!done, "R9 done single cycle", {63'b0, done}, 64'h0);
    repeat (3) @(negedge clk);
    check({tag_err, data_err, way_err, lru_order} == {et, ed, ew, el}, "R9 flags hold while idle",
          {50'b0, tag_err, data_err, way_err, lru_order}, {50'b0, et, ed, ew, el});
    check(addr_q.size() == 0, "R1 all reads issued", 64'(addr_q.size()), 64'h0);
  endtask

  initial begin
    for (int w = 0; w < 4; w++) begin
      m_thi[w] = '0; m_tlo[w] = '0;
      for (int o = 0; o < 4; o++) begin m_side[w][o] = '0; m_dlo[w][o] = '0; end
    end
    repeat (4) @(negedge clk);
    check({busy, done, rd_en, tag_err, data_err, way_err, lru_order} == 17'h0, "R11 reset state",
          {47'b0, busy, done, rd_en, tag_err, data_err, way_err, lru_order}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R8: clean set, data check on
    fill(10, 8'hE4);
    run(13'h0A60, 1'b1, 1'b0, 1'b0, 4'b0000, 8'hE4, "R8 clean scan and lru", 1'b0);

    // R2: valid parity copy flipped on way 2
    fill(20, 8'h1B);
    m_thi[2][27] = ~m_thi[2][27];
    run(13'h1FE0, 1'b0, 1'b1, 1'b0, 4'b0100, 8'h1B, "R2 valid-bit parity", 1'b0);

    // R3: invalid way 1 with bad low parity ignored, valid way 3 high-range flip flagged
    fill(30, 8'h39);
    m_thi[1][29] = 1'b0; m_thi[1][27] = 1'b0;
    m_tlo[1][10] = ~m_tlo[1][10];
    m_tlo[3][40] = ~m_tlo[3][40];
    run(13'h0020, 1'b0, 1'b1, 1'b0, 4'b1000, 8'h39, "R3 invalid ignored, high-range parity", 1'b0);

    // R2: invalid line whose parity copy disagrees still flagged
    fill(40, 8'hD8);
    m_thi[0][29] = 1'b0;
    run(13'h0A60, 1'b0, 1'b1, 1'b0, 4'b0001, 8'hD8, "R2 invalid line valid-bit parity", 1'b0);

    // R3 R7: low-range tag field flip on way 1, data clean
    fill(50, 8'h4E);
    m_tlo[1][5] = ~m_tlo[1][5];
    run(13'h1100, 1'b1, 1'b1, 1'b0, 4'b0010, 8'h4E, "R3 low-range tag parity", 1'b0);

    // R5: predecode parity bit flip
    fill(60, 8'h93);
    m_side[0][2][16] = ~m_side[0][2][16];
    run(13'h0A60, 1'b1, 1'b0, 1'b1, 4'b0001, 8'h93, "R5 predecode parity", 1'b0);

    // R6: paired flip on byte 3 of A and side bit 7 cancels; B byte 0 flip detected
    fill(70, 8'hC6);
    m_dlo[3][3][63]  = ~m_dlo[3][3][63];
    m_side[3][3][7]  = ~m_side[3][3][7];
    m_dlo[2][1][0]   = ~m_dlo[2][1][0];
    run(13'h0060, 1'b1, 1'b0, 1'b1, 4'b0100, 8'hC6, "R6 byte parity order", 1'b0);

    // R4: same corrupted data, data check off
    run(13'h0060, 1'b0, 1'b0, 1'b0, 4'b0000, 8'hC6, "R4 data ignored when off", 1'b0);

    // R7: errors in several ways at once
    fill(90, 8'h27);
    m_thi[0][27] = ~m_thi[0][27];
    m_side[2][0][12] = ~m_side[2][0][12];
    run(13'h0AE0, 1'b1, 1'b1, 1'b1, 4'b0101, 8'h27, "R7 per-way vector", 1'b0);

    // R10: start while busy ignored
    fill(80, 8'h72);
    run(13'h0A60, 1'b1, 1'b0, 1'b0, 4'b0000, 8'h72, "R10 start during scan ignored", 1'b1);

    check(res_q.size() == 0, "R9 every scan ended with done", 64'(res_q.size()), 64'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule